// File: doc/BRIEF.md
# 16-bit Arithmetic and Logic Unit with Status Flags

This block is the arithmetic engine of a small 16-bit datapath. It takes two 16-bit operands and a 3-bit operation select. It returns a 16-bit result together with four status bits: zero, negative, carry and overflow. It has no clock and no internal state, so the outputs follow the inputs within the same cycle.

A separate compare input turns any request into a subtraction. In that case the flags keep their normal meaning, but the result write-enable is lowered so the caller leaves its destination register untouched. Every operation produces a complete flag set, so the flag write-enable output is always high. The caller owns the flags register and the operand selection.

Top module: `alu16`

## Requirements
- R1: With cmp_i low and op_i = 3'b000, res_o equals (a_i + b_i) modulo 2^16.
- R2: With cmp_i low and op_i = 3'b001, res_o equals (a_i - b_i) modulo 2^16.
- R3: With cmp_i low, the select codes map to bitwise operations as follows: op_i = 3'b010 gives a_i AND b_i, 3'b011 gives a_i OR b_i, 3'b100 gives a_i XOR b_i, and 3'b101 gives NOT a_i (b_i is ignored).
- R4: With cmp_i low, op_i = 3'b110 shifts a_i left by one bit and fills bit 0 with 0. op_i = 3'b111 shifts a_i right by one bit and fills bit 15 with 0.
- R5: zero_o is 1 exactly when res_o is 16'h0000.
- R6: neg_o always equals res_o[15].
- R7: For addition, carry_o is the carry out of bit 15. For subtraction and compare, carry_o is 1 exactly when a_i >= b_i as unsigned values (no borrow).
- R8: For addition, ovf_o is 1 when the operands share a sign and res_o has the other sign. For subtraction and compare, ovf_o is 1 when the operands differ in sign and res_o[15] differs from a_i[15].
- R9: For a left shift, carry_o equals a_i[15]. For a right shift, carry_o equals a_i[0]. For both shifts ovf_o is 0. For the four bitwise operations, carry_o and ovf_o are both 0.
- R10: With cmp_i high, res_o and all flags are those of a subtraction whatever op_i holds, and res_we_o is 0. With cmp_i low, res_we_o is 1.
- R11: flag_we_o is 1 for every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| op_i | input | 3 | Operation select |
| cmp_i | input | 1 | Compare request: forces subtraction and discards the result |
| res_o | output | 16 | Operation result |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result sign bit |
| carry_o | output | 1 | Carry, no-borrow or shifted-out bit |
| ovf_o | output | 1 | Signed overflow |
| res_we_o | output | 1 | Destination register write-enable |
| flag_we_o | output | 1 | Flags register write-enable |

## Verification
Every result and flag of this block is due in the same cycle as its operands, because no register lies between any input and any output. The bench changes the operands, select and compare input on the falling clock edge and samples all outputs one nanosecond later, before the next rising edge. At that point the combinational paths have settled and no process ordering at an edge can affect the values read. The expected values come from integer arithmetic with explicit signed range tests, not from a bit-level copy of the design.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_NOT = 3'b101,
    OP_SHL = 3'b110,
    OP_SHR = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  // subtraction as a + ~b + 1; carry out then means no borrow
  assign b_eff   = sub_i ? ~b_i : b_i;
  assign full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         left_i,
  output logic [W-1:0] res_o,
  output logic         out_bit_o
);
  always_comb begin
    if (left_i) begin
      res_o     = {a_i[W-2:0], 1'b0};
      out_bit_o = a_i[W-1];
    end else begin
      res_o     = {1'b0, a_i[W-1:1]};
      out_bit_o = a_i[0];
    end
  end
endmodule

// File: rtl/alu16.sv
module alu16
  import alu16_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            cmp_i,
  output logic [W-1:0]    res_o,
  output logic            zero_o,
  output logic            neg_o,
  output logic            carry_o,
  output logic            ovf_o,
  output logic            res_we_o,
  output logic            flag_we_o
);
  alu_op_e      eff_op;
  logic [W-1:0] arith_res, logic_res, shift_res;
  logic         arith_c, arith_v, shift_c;

  // compare overrides the select with subtraction
  assign eff_op = cmp_i ? OP_SUB : alu_op_e'(op_i);

  alu16_addsub #(.W(W)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (eff_op == OP_SUB),
    .sum_o   (arith_res),
    .carry_o (arith_c),
    .ovf_o   (arith_v)
  );

  alu16_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (eff_op),
    .res_o (logic_res)
  );

  alu16_shift #(.W(W)) u_shift (
    .a_i       (a_i),
    .left_i    (eff_op == OP_SHL),
    .res_o     (shift_res),
    .out_bit_o (shift_c)
  );

  always_comb begin
    unique case (eff_op)
      OP_ADD, OP_SUB: begin
        res_o   = arith_res;
        carry_o = arith_c;
        ovf_o   = arith_v;
      end
      OP_SHL, OP_SHR: begin
        res_o   = shift_res;
        carry_o = shift_c;
        ovf_o   = 1'b0;
      end
      default: begin
        res_o   = logic_res;
        carry_o = 1'b0;
        ovf_o   = 1'b0;
      end
    endcase
  end

  assign zero_o    = (res_o == '0);
  assign neg_o     = res_o[W-1];
  assign res_we_o  = ~cmp_i;
  assign flag_we_o = 1'b1;
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
  parameter int unsigned W = 16
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   op_i,
  input logic         cmp_i,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         res_we_o,
  input logic         flag_we_o
);
  logic known;
  assign known = !$isunknown({a_i, b_i, op_i, cmp_i});

  always_comb begin
    if (known) begin
      // R10
      cmp_discard_chk: assert (res_we_o == !cmp_i) else $error("res_we_o wrong");
      // R11
      flag_we_chk: assert (flag_we_o) else $error("flag_we_o low");
      // R5
      zero_flag_chk: assert (zero_o == (res_o == '0)) else $error("zero flag wrong");
      // R6
      neg_flag_chk: assert (neg_o == res_o[W-1]) else $error("neg flag wrong");
      // R7
      no_borrow_chk: assert (!(cmp_i || op_i == 3'b001) || (carry_o == (a_i >= b_i)))
        else $error("sub carry wrong");
      // R9
      logic_cv_chk: assert (cmp_i || !(op_i inside {3'b010, 3'b011, 3'b100, 3'b101})
                            || (!carry_o && !ovf_o))
        else $error("logic op flags wrong");
      // R9
      shl_carry_chk: assert (cmp_i || op_i != 3'b110 || (carry_o == a_i[W-1] && !ovf_o))
        else $error("shl carry wrong");
      // R9
      shr_carry_chk: assert (cmp_i || op_i != 3'b111 || (carry_o == a_i[0] && !ovf_o))
        else $error("shr carry wrong");
    end
  end
endmodule

bind alu16 alu16_chk #(.W(W)) chk_i (
  .a_i       (a_i),
  .b_i       (b_i),
  .op_i      (op_i),
  .cmp_i     (cmp_i),
  .res_o     (res_o),
  .zero_o    (zero_o),
  .neg_o     (neg_o),
  .carry_o   (carry_o),
  .ovf_o     (ovf_o),
  .res_we_o  (res_we_o),
  .flag_we_o (flag_we_o)
);

// File: tb/alu16_tb_top.sv
module alu16_tb_top;
  logic        clk;
  logic        rst_ni;
  logic [15:0] a, b, res;
  logic [2:0]  op;
  logic        cmp, z, n, c, v, rwe, fwe;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  alu16 dut_i (
    .a_i(a), .b_i(b), .op_i(op), .cmp_i(cmp),
    .res_o(res), .zero_o(z), .neg_o(n), .carry_o(c), .ovf_o(v),
    .res_we_o(rwe), .flag_we_o(fwe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int ai, input int bi, input int opi, input bit cmpi);
    @(negedge clk);
    a = ai[15:0]; b = bi[15:0]; op = opi[2:0]; cmp = cmpi;
    #1;
  endtask

  // expected values from integer arithmetic
  task automatic verify(input string req, input int ai, input int bi, input int opi, input bit cmpi);
    int ua, ub, sa, sb, r, ec, ev, full, sfull;
    int eop;
    drive(ai, bi, opi, cmpi);
    ua = ai & 16'hffff; ub = bi & 16'hffff;
    sa = (ua >= 32768) ? ua - 65536 : ua;
    sb = (ub >= 32768) ? ub - 65536 : ub;
    eop = cmpi ? 1 : opi;
    ec = 0; ev = 0;
    case (eop)
      0: begin full = ua + ub; sfull = sa + sb; r = full & 16'hffff;
               ec = int'(full > 65535); ev = int'(sfull > 32767 || sfull < -32768); end
      1: begin sfull = sa - sb; r = (ua - ub) & 16'hffff;
               ec = int'(ua >= ub); ev = int'(sfull > 32767 || sfull < -32768); end
      2: r = ua & ub;
      3: r = ua | ub;
      4: r = ua ^ ub;
      5: r = (~ua) & 16'hffff;
      6: begin r = (ua * 2) & 16'hffff; ec = ua / 32768; end
      default: begin r = ua / 2; ec = ua % 2; end
    endcase
    chk(req, "result", int'(res), r);
    chk("R5", "zero", int'(z), int'(r == 0));
    chk("R6", "neg", int'(n), r / 32768);
    chk((eop <= 1) ? "R7" : "R9", "carry", int'(c), ec);
    chk((eop <= 1) ? "R8" : "R9", "ovf", int'(v), ev);
    chk("R10", "res_we", int'(rwe), int'(!cmpi));
    chk("R11", "flag_we", int'(fwe), 1);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    a = '0; b = '0; op = '0; cmp = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R5", "idle zero", int'(z), 1);
    chk("R1", "idle result", int'(res), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_add;
    verify("R1", 5, 7, 0, 0);
    verify("R1", 16'hffff, 1, 0, 0);
    verify("R1", 16'h7fff, 1, 0, 0);
    verify("R1", 16'h8000, 16'h8000, 0, 0);
    verify("R1", 16'h1234, 16'h4321, 0, 0);
  endtask

  task automatic t_sub;
    verify("R2", 12, 12, 1, 0);
    verify("R2", 3, 5, 1, 0);
    verify("R2", 16'h8000, 1, 1, 0);
    verify("R2", 16'h7fff, 16'hffff, 1, 0);
    verify("R2", 16'h0000, 16'h0000, 1, 0);
  endtask

  task automatic t_logic;
    for (int k = 2; k <= 5; k++) begin
      verify("R3", 16'hf0f0, 16'h3c3c, k, 0);
      verify("R3", 16'hffff, 16'h0000, k, 0);
    end
    verify("R3", 16'h00ff, 16'hff00, 2, 0);
  endtask

  task automatic t_shift;
    verify("R4", 16'h8001, 0, 6, 0);
    verify("R4", 16'h8001, 0, 7, 0);
    verify("R4", 16'h4000, 16'hffff, 6, 0);
    verify("R4", 16'h0001, 16'hffff, 7, 0);
    verify("R4", 16'h8000, 0, 7, 0);
  endtask

  task automatic t_cmp;
    for (int k = 0; k < 8; k++) verify("R10", 12, 12, k, 1);
    verify("R10", 3, 9, 6, 1);
    verify("R10", 16'h8000, 16'h0001, 2, 1);
    verify("R10", 16'h7fff, 16'h8000, 0, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_cmp();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule